// File: doc/BRIEF.md
# Serial Register-Access Target

This block is a serial bus target that gives a host processor read and write access to a small bank of 8-bit registers. The host selects the target with an active-low select line and clocks it in SPI mode 0. Every transaction starts with a 16-bit instruction that carries a direction flag and a 15-bit register address. One data byte follows it, or several when streaming is on. While streaming, the address moves by one after every byte, either upward or downward, and wraps around at the ends of the address space.

Four static configuration inputs set how each transaction runs: bit order, streaming, address direction, and whether the bus uses four wires or three. The block copies them at the moment select goes active, so a change during a transaction has no effect until the next one. All serial inputs are synchronised into the system clock domain and their edges are detected there. The bank keeps one write port for the serial side and adds a parallel read port so that on-chip logic can observe the registers.

Top module: `spi_reg_target`

## Requirements
- R1: After reset every bank register reads 0 on the parallel port, `spi_miso` is 0 and `sdio_oe` is 0. The latched configuration starts as most-significant-bit first, no streaming, incrementing, 4-wire.
- R2: The instruction is the word {rd, addr[14:0]}, where rd=1 means read. In MSB-first order it is sent bit 15 first. In LSB-first order it is sent bit 0 first, so the rd flag is the last instruction bit. The bank holds 32 registers and decodes only addr[4:0], so higher addresses alias.
- R3: With `cfg_msb_first`=1 the data bits travel D7 first. With 0 they travel D0 first. This holds in both directions.
- R4: A write updates the addressed register after the eighth data bit has been sampled and before select is released.
- R5: Read data is launched after falling clock edges and is valid at the next rising edge. Each byte returns the register contents as they stood when that byte began.
- R6: With streaming off, exactly one byte moves. Further clocks before select rises change no register, including the neighbours of the addressed one.
- R7: With streaming on and `cfg_addr_up`=1, each following byte uses the previous address plus one.
- R8: With streaming on and `cfg_addr_up`=0, each following byte uses the previous address minus one.
- R9: While streaming, the address wraps modulo 2^15: 0x7FFF+1 gives 0, and 0-1 gives 0x7FFF.
- R10: In 3-wire mode (`cfg_four_wire`=0), host bits arrive on `sdio_i`. Read bits leave on `sdio_o`, and `sdio_oe` is 1 only during the data bit periods of a read. It is 0 during the instruction and whenever select is inactive.
- R11: In 4-wire mode, host bits arrive on `spi_mosi` and read bits leave on `spi_miso`, while `sdio_oe` stays 0. In 3-wire mode `spi_miso` stays 0.
- R12: Raising select in the middle of a byte discards that byte without a write. The next transaction starts from a clean instruction phase.
- R13: The configuration inputs are sampled only when select goes active. Changing them mid-transaction does not alter that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_stream_en | input | 1 | 1: multi-byte streaming |
| cfg_addr_up | input | 1 | 1: address steps up, 0: down |
| cfg_four_wire | input | 1 | 1: 4-wire, 0: 3-wire |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Host-to-target data, 4-wire |
| spi_miso | output | 1 | Target-to-host data, 4-wire |
| sdio_i | input | 1 | Shared data pin, input side |
| sdio_o | output | 1 | Shared data pin, output side |
| sdio_oe | output | 1 | Shared data pin output enable |
| bank_rd_idx | input | 5 | Parallel read index |
| bank_rd_data | output | 8 | Parallel read data |

## Verification
When a streamed write reaches the top address, two things happen on the same sampled edge: the byte that completes there is written, and the address steps and wraps to zero for the next byte. The test provokes this with a three-byte upward write starting at 0x7FFE. It then checks through the parallel port that index 31 holds the second byte and index 0 holds the third, with nothing lost or misplaced across the wrap. The downward case reads across address zero in the same way and expects the wrapped register's contents in the third byte.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INSTR = 2'd1,
    PH_DATA  = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  typedef struct packed {
    logic msb_first;
    logic stream_en;
    logic addr_up;
    logic four_wire;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{msb_first: 1'b1, stream_en: 1'b0,
                                 addr_up: 1'b1, four_wire: 1'b1};

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_tgt_front.sv
module spi_tgt_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic sdio_i,
  output logic cs_act,
  output logic cs_start,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic sdio_s
);

  // bit order in the synchronised vector: {sclk, cs_n, mosi, sdio}
  localparam int NSIG = 4;
  localparam logic [NSIG-1:0] SYNC_RST = 4'b0100;

  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] syn;
  logic            sclk_d_q;
  logic            cs_act_d_q;
  logic            sclk_s;

  assign raw_in = {spi_sclk, spi_cs_n, spi_mosi, sdio_i};

  spi_tgt_sync #(
    .W      (NSIG),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (syn)
  );

  assign sclk_s = syn[3];
  assign cs_act = ~syn[2];
  assign mosi_s = syn[1];
  assign sdio_s = syn[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q   <= 1'b0;
      cs_act_d_q <= 1'b0;
    end else begin
      sclk_d_q   <= sclk_s;
      cs_act_d_q <= cs_act;
    end
  end

  assign cs_start = cs_act & ~cs_act_d_q;
  assign sck_rise = cs_act & sclk_s & ~sclk_d_q;
  assign sck_fall = cs_act & ~sclk_s & sclk_d_q;

endmodule

// File: rtl/spi_tgt_bank.sv
module spi_tgt_bank #(
  parameter int DEPTH = 32,
  parameter int DW = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_data
);

  logic [DW-1:0] mem_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem_q[g] <= '0;
        else if (hit) mem_q[g] <= wr_data;
      end
    end
  endgenerate

  assign rd_a_data = mem_q[rd_a_idx];
  assign rd_b_data = mem_q[rd_b_idx];

endmodule

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl
  import spi_tgt_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int IDX_W = 5,
  parameter int DW = 8,
  localparam int INSTR_W = ADDR_W + 1,
  localparam int CNT_W = $clog2(INSTR_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg_in,
  input  logic             cs_act,
  input  logic             cs_start,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             mosi_s,
  input  logic             sdio_s,
  input  logic [DW-1:0]    look_data,
  output logic [IDX_W-1:0] look_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             out_bit,
  output logic             drive,
  output logic             four_q,
  output phase_e           phase
);

  phase_e              phase_q, phase_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [INSTR_W-1:0]  instr_q, instr_n, instr_shift;
  logic [ADDR_W-1:0]   addr_q, addr_n, step_addr;
  logic                rd_q, rd_n;
  logic [DW-1:0]       rx_q, rx_n, rx_shift;
  logic [DW-1:0]       tx_q, tx_n;
  logic                out_q, out_n;
  logic                drive_q, drive_n;
  cfg_t                cfg_q, cfg_n;
  logic                wr_en_q, wr_en_n;
  logic [IDX_W-1:0]    wr_idx_q, wr_idx_n;
  logic [DW-1:0]       wr_data_q, wr_data_n;
  logic                din;
  logic [ADDR_W-1:0]   look_addr;

  // next-state logic
  always_comb begin
    phase_n   = phase_q;
    cnt_n     = cnt_q;
    instr_n   = instr_q;
    addr_n    = addr_q;
    rd_n      = rd_q;
    rx_n      = rx_q;
    tx_n      = tx_q;
    out_n     = out_q;
    drive_n   = drive_q;
    cfg_n     = cfg_q;
    wr_en_n   = 1'b0;
    wr_idx_n  = wr_idx_q;
    wr_data_n = wr_data_q;

    din         = cfg_q.four_wire ? mosi_s : sdio_s;
    instr_shift = cfg_q.msb_first ? {instr_q[INSTR_W-2:0], din}
                                  : {din, instr_q[INSTR_W-1:1]};
    rx_shift    = cfg_q.msb_first ? {rx_q[DW-2:0], din}
                                  : {din, rx_q[DW-1:1]};
    step_addr   = cfg_q.addr_up ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);
    look_addr   = (phase_q == PH_INSTR) ? instr_shift[ADDR_W-1:0] : step_addr;

    if (!cs_act) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
      drive_n = 1'b0;
    end else if (cs_start) begin
      phase_n = PH_INSTR;
      cnt_n   = '0;
      drive_n = 1'b0;
      cfg_n   = cfg_in;
    end else begin
      case (phase_q)
        PH_INSTR: begin
          if (sck_rise) begin
            instr_n = instr_shift;
            if (cnt_q == CNT_W'(INSTR_W - 1)) begin
              rd_n    = instr_shift[INSTR_W-1];
              addr_n  = instr_shift[ADDR_W-1:0];
              tx_n    = look_data;
              phase_n = PH_DATA;
              cnt_n   = '0;
            end else begin
              cnt_n = cnt_q + CNT_W'(1);
            end
          end
        end
        PH_DATA: begin
          if (sck_rise) begin
            rx_n = rx_shift;
            if (cnt_q == CNT_W'(DW - 1)) begin
              cnt_n = '0;
              if (!rd_q) begin
                wr_en_n   = 1'b1;
                wr_idx_n  = addr_q[IDX_W-1:0];
                wr_data_n = rx_shift;
              end
              if (cfg_q.stream_en) begin
                addr_n = step_addr;
                tx_n   = look_data;
              end else begin
                phase_n = PH_DONE;
                drive_n = 1'b0;
              end
            end else begin
              cnt_n = cnt_q + CNT_W'(1);
            end
          end else if (sck_fall && rd_q) begin
            out_n   = cfg_q.msb_first ? tx_q[DW-1] : tx_q[0];
            tx_n    = cfg_q.msb_first ? {tx_q[DW-2:0], 1'b0} : {1'b0, tx_q[DW-1:1]};
            drive_n = 1'b1;
          end
        end
        default: begin
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      instr_q   <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      rx_q      <= '0;
      tx_q      <= '0;
      out_q     <= 1'b0;
      drive_q   <= 1'b0;
      cfg_q     <= CFG_RESET;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      phase_q   <= phase_n;
      cnt_q     <= cnt_n;
      instr_q   <= instr_n;
      addr_q    <= addr_n;
      rd_q      <= rd_n;
      rx_q      <= rx_n;
      tx_q      <= tx_n;
      out_q     <= out_n;
      drive_q   <= drive_n;
      cfg_q     <= cfg_n;
      wr_en_q   <= wr_en_n;
      wr_idx_q  <= wr_idx_n;
      wr_data_q <= wr_data_n;
    end
  end

  assign look_idx = look_addr[IDX_W-1:0];
  assign wr_en    = wr_en_q;
  assign wr_idx   = wr_idx_q;
  assign wr_data  = wr_data_q;
  assign out_bit  = out_q;
  assign drive    = drive_q;
  assign four_q   = cfg_q.four_wire;
  assign phase    = phase_q;

endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
  import spi_tgt_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DEPTH = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_msb_first,
  input  logic             cfg_stream_en,
  input  logic             cfg_addr_up,
  input  logic             cfg_four_wire,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe,
  input  logic [IDX_W-1:0] bank_rd_idx,
  output logic [7:0]       bank_rd_data
);

  localparam int DW = 8;

  logic             rst_meta_q, rst_sync_n;
  logic             cs_act, cs_start, sck_rise, sck_fall, mosi_s, sdio_s;
  logic [IDX_W-1:0] look_idx, wr_idx;
  logic [DW-1:0]    look_data, wr_data;
  logic             wr_en, out_bit, drive, four_q;
  phase_e           phase;
  cfg_t             cfg_in;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign cfg_in = '{msb_first: cfg_msb_first, stream_en: cfg_stream_en,
                    addr_up: cfg_addr_up, four_wire: cfg_four_wire};

  spi_tgt_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi),
    .sdio_i  (sdio_i),
    .cs_act  (cs_act),
    .cs_start(cs_start),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .mosi_s  (mosi_s),
    .sdio_s  (sdio_s)
  );

  spi_tgt_ctrl #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .DW    (DW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_in   (cfg_in),
    .cs_act   (cs_act),
    .cs_start (cs_start),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .sdio_s   (sdio_s),
    .look_data(look_data),
    .look_idx (look_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .out_bit  (out_bit),
    .drive    (drive),
    .four_q   (four_q),
    .phase    (phase)
  );

  spi_tgt_bank #(
    .DEPTH(DEPTH),
    .DW   (DW)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_a_idx (look_idx),
    .rd_a_data(look_data),
    .rd_b_idx (bank_rd_idx),
    .rd_b_data(bank_rd_data)
  );

  assign spi_miso = drive & four_q & out_bit;
  assign sdio_o   = drive & out_bit;
  assign sdio_oe  = drive & ~four_q & (phase == PH_DATA);

endmodule

// File: rtl/spi_reg_target_chk.sv
module spi_reg_target_chk
  import spi_tgt_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cs_act,
  input logic   wr_en,
  input logic   sdio_oe,
  input logic   four_q,
  input phase_e phase
);

  // R4: a byte completes at most every eighth sampled edge
  p_wr_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R12: a write only follows a cycle with select active
  p_wr_needs_select_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cs_act));

  // R10: shared pin is released once select drops
  p_release_on_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdio_oe);

  // R10: output enable only starts inside a data phase
  p_oe_in_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(phase) == PH_DATA);

  // R6: nothing is written once the single byte is finished
  p_done_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |=> !wr_en);

  // R13: latched wire mode holds for the whole transaction
  p_cfg_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(four_q));

endmodule

bind spi_reg_target spi_reg_target_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .cs_act (cs_act),
  .wr_en  (wr_en),
  .sdio_oe(sdio_oe),
  .four_q (four_q),
  .phase  (phase)
);

// File: tb/sim_spi_reg_target.sv
`timescale 1ns/1ps
module sim_spi_reg_target;

  localparam int HALF = 6;
  localparam int NVEC = 8;
  // {msb_first, four_wire, rd, addr[14:0], data[7:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 15'h0003, 8'hA5},
    {1'b0, 1'b1, 1'b0, 15'h0004, 8'h3C},
    {1'b1, 1'b0, 1'b0, 15'h0005, 8'h81},
    {1'b0, 1'b0, 1'b0, 15'h0106, 8'h5E},
    {1'b1, 1'b1, 1'b1, 15'h0003, 8'hA5},
    {1'b0, 1'b1, 1'b1, 15'h0004, 8'h3C},
    {1'b1, 1'b0, 1'b1, 15'h0005, 8'h81},
    {1'b0, 1'b0, 1'b1, 15'h0006, 8'h5E}
  };

  logic clk, rst_n;
  logic cfg_msb, cfg_strm, cfg_up, cfg_four;
  logic sclk, cs_n, mosi, host_bit;
  logic miso, sdio_o, sdio_oe, sdio_line;
  logic [4:0] rd_idx;
  logic [7:0] rd_data;

  int checks, fails, oe_err;
  logic oe_seen;
  logic [7:0] tx_b [4];
  logic [7:0] rx_b [4];
  logic [7:0] snap;

  assign sdio_line = sdio_oe ? sdio_o : host_bit;

  spi_reg_target u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_msb_first(cfg_msb),
    .cfg_stream_en(cfg_strm),
    .cfg_addr_up  (cfg_up),
    .cfg_four_wire(cfg_four),
    .spi_sclk     (sclk),
    .spi_cs_n     (cs_n),
    .spi_mosi     (mosi),
    .spi_miso     (miso),
    .sdio_i       (sdio_line),
    .sdio_o       (sdio_o),
    .sdio_oe      (sdio_oe),
    .bank_rd_idx  (rd_idx),
    .bank_rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic bank_chk(input string tag, input logic [4:0] idx, input logic [7:0] exp);
    @(negedge clk);
    rd_idx = idx;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic sclk_bit(input logic b, output logic got);
    host_bit = b;
    mosi     = b;
    repeat (HALF) @(negedge clk);
    got     = cfg_four ? miso : sdio_line;
    oe_seen = sdio_oe;
    if (!cfg_four && miso) oe_err++;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic msb, input logic four, input logic strm,
                      input logic up, input logic rd, input logic [14:0] addr,
                      input int nbytes, input int last_bits, input int extra,
                      input bit flip);
    logic [15:0] ins;
    logic got;
    int k;
    ins = {rd, addr};
    cfg_msb = msb; cfg_four = four; cfg_strm = strm; cfg_up = up;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      k = msb ? 15 - i : i;
      sclk_bit(ins[k], got);
      if (oe_seen) oe_err++;
    end
    if (flip) cfg_msb = ~msb;
    for (int b = 0; b < nbytes; b++) begin
      int nb;
      nb = (b == nbytes - 1) ? last_bits : 8;
      for (int i = 0; i < nb; i++) begin
        k = msb ? 7 - i : i;
        sclk_bit(rd ? 1'b0 : tx_b[b][k], got);
        rx_b[b][k] = got;
        if (rd && !four) begin
          if (!oe_seen) oe_err++;
        end else if (oe_seen) begin
          oe_err++;
        end
      end
    end
    for (int i = 0; i < extra; i++) begin
      sclk_bit(1'b1, got);
      if (oe_seen) oe_err++;
    end
    repeat (HALF) @(negedge clk);
    snap = rd_data;
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    if (sdio_oe) oe_err++;
    cfg_msb = msb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    checks = 0; fails = 0; oe_err = 0;
    rst_n = 1'b0;
    cfg_msb = 1'b1; cfg_strm = 1'b0; cfg_up = 1'b1; cfg_four = 1'b1;
    sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; host_bit = 1'b0;
    rd_idx = '0;
    for (int i = 0; i < 4; i++) begin
      tx_b[i] = '0;
      rx_b[i] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk("R1 miso idle", {7'd0, miso}, 8'h00);
    chk("R1 oe idle", {7'd0, sdio_oe}, 8'h00);
    bank_chk("R1 bank cleared", 5'd3, 8'h00);

    // table walk: single-byte writes, then reads, both orders, both wire modes
    for (int v = 0; v < NVEC; v++) begin
      logic [25:0] e;
      e = VEC[v];
      tx_b[0] = e[7:0];
      xfer(e[25], e[24], 1'b0, 1'b1, e[23], e[22:8], 1, 8, 0, 1'b0);
      if (e[23]) chk($sformatf("R3 R5 R2 read vec %0d", v), rx_b[0], e[7:0]);
      else       bank_chk($sformatf("R3 R2 write vec %0d", v), e[12:8], e[7:0]);
    end

    // R7 R9: streamed upward write across the top of the address space
    tx_b[0] = 8'h11; tx_b[1] = 8'h22; tx_b[2] = 8'h33;
    xfer(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 15'h7FFE, 3, 8, 0, 1'b0);
    bank_chk("R7 stream up first", 5'd30, 8'h11);
    bank_chk("R7 R9 stream up at top", 5'd31, 8'h22);
    bank_chk("R9 stream up wrapped", 5'd0, 8'h33);

    // R8 R9: streamed downward read across zero
    xfer(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 15'h0001, 3, 8, 0, 1'b0);
    chk("R8 stream down byte0", rx_b[0], 8'h00);
    chk("R8 stream down byte1", rx_b[1], 8'h33);
    chk("R9 stream down wrapped", rx_b[2], 8'h22);

    // R8 R10: downward streamed write in 3-wire LSB-first
    tx_b[0] = 8'h44; tx_b[1] = 8'h55;
    xfer(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 15'h0010, 2, 8, 0, 1'b0);
    bank_chk("R8 R10 3-wire stream idx16", 5'd16, 8'h44);
    bank_chk("R8 R10 3-wire stream idx15", 5'd15, 8'h55);

    // R10 R5: streamed 3-wire read upward
    xfer(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 15'h000F, 2, 8, 0, 1'b0);
    chk("R10 R5 3-wire read byte0", rx_b[0], 8'h55);
    chk("R10 R5 3-wire read byte1", rx_b[1], 8'h44);

    // R6 R4: single byte, extra clocks ignored; write visible before select rises
    @(negedge clk); rd_idx = 5'd8;
    tx_b[0] = 8'h96;
    xfer(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 15'h0008, 1, 8, 8, 1'b0);
    chk("R4 write before deselect", snap, 8'h96);
    bank_chk("R6 target kept", 5'd8, 8'h96);
    bank_chk("R6 upper neighbour", 5'd9, 8'h00);
    bank_chk("R6 lower neighbour", 5'd7, 8'h00);

    // R12: abort mid-byte, then a clean read
    tx_b[0] = 8'h00;
    xfer(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 15'h0003, 1, 5, 0, 1'b0);
    bank_chk("R12 aborted byte not written", 5'd3, 8'hA5);
    xfer(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 15'h0003, 1, 8, 0, 1'b0);
    chk("R12 next transaction clean", rx_b[0], 8'hA5);

    // R13: bit-order input flipped mid-transaction
    tx_b[0] = 8'hC1;
    xfer(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 15'h000C, 1, 8, 0, 1'b1);
    bank_chk("R13 config held", 5'd12, 8'hC1);

    // R10 R11: enable behaviour collected over every transaction
    chk("R10 R11 output enable windows", oe_err[7:0], 8'h00);
    chk("R10 oe released at end", {7'd0, sdio_oe}, 8'h00);

    report();
    $finish;
  end

endmodule